// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block tracks the loads an out-of-order core has in flight. Each dispatched load takes a slot index from a pool of free slots and is stamped with its 16-bit sequence number. The execute stage later reports the load's effective address against that slot, and the slot is then marked as having run. Commit retires every load up to a sequence-number bound. A squash discards every load beyond a bound.

When a store executes, the block probes the queue for loads that are younger than the store, have already run, and touched the same 256-byte block. The oldest such load becomes the recorded violator, a violation counter advances, and a fault pulse is returned for the probe. Only one violator is held at a time. While one is held, probes make no check. Reading the violator hands it over and clears the register.

A separate pair of flags follows a load that is blocked on a cache stall. A squash that reaches past that load releases the flags. The block also reports how many memory operations may still be dispatched. That figure is the tighter of the load and store free counts, less one reserved slot.

Top module: `load_order_queue`

## Requirements
- R1: After reset the queue is empty, `disp_ready` is 1, `disp_idx` is 0, no violator is held, `viol_count` is 0 and both blocked flags and `blk_seq_q` are 0.
- R2: A dispatch is accepted only while fewer than DEPTH-1 loads are held (`disp_ready`=1). It takes the lowest-numbered free slot, which `disp_idx` shows. A dispatch while `disp_ready`=0 has no effect.
- R3: A commit removes every held load whose sequence number is less than or equal to `cmt_seq`, and returns its slot to the free pool.
- R4: A squash removes every held load whose sequence number is greater than `sqsh_seq`, and returns its slot to the free pool. Loads at or below the bound stay.
- R5: An address update on a held slot records the address and marks the load as executed. Loads that have not executed never conflict.
- R6: A probe conflicts with a held, executed load only when the load's sequence number is greater than `st_seq` and bits [ADDRW-1:8] of the two addresses are equal. Older loads and loads in other 256-byte blocks are skipped.
- R7: On a conflict, the oldest conflicting load's sequence number and slot become the violator, `viol_count` increments, and `st_fault` is 1 for the cycle after the probe. A probe with no conflict leaves `st_fault` 0 and no violator.
- R8: While a violator is held, a probe makes no check: `st_fault` stays 0, and `viol_count` and the violator do not change.
- R9: `viol_read` with a violator held clears `viol_valid` in the next cycle.
- R10: `blk_set` records `blk_seq` and sets `blk_active`. `blk_ack` sets `blk_handled`. A squash whose bound is less than `blk_seq_q` clears both flags and zeroes `blk_seq_q`. A squash at or above it leaves them unchanged.
- R11: `free_cnt` equals min(DEPTH minus held loads, `sq_free`) minus 1, saturating at 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch a load |
| disp_seq | input | SEQW | Sequence number of dispatched load |
| disp_ready | output | 1 | Queue can accept a load |
| disp_idx | output | IDXW | Slot the next dispatch takes |
| exec_valid | input | 1 | Load address update |
| exec_idx | input | IDXW | Slot being updated |
| exec_addr | input | ADDRW | Effective address of the load |
| st_valid | input | 1 | Store-execute probe |
| st_seq | input | SEQW | Store sequence number |
| st_addr | input | ADDRW | Store address |
| st_fault | output | 1 | Probe found a violation (one cycle later) |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQW | Commit bound |
| sqsh_valid | input | 1 | Squash request |
| sqsh_seq | input | SEQW | Squash bound |
| blk_set | input | 1 | Mark a load blocked |
| blk_seq | input | SEQW | Sequence number of blocked load |
| blk_ack | input | 1 | Mark the block as handled |
| blk_active | output | 1 | A load is blocked |
| blk_handled | output | 1 | The block has been handled |
| blk_seq_q | output | SEQW | Recorded blocked sequence number |
| viol_read | input | 1 | Read and clear the violator |
| viol_valid | output | 1 | Violator held |
| viol_seq | output | SEQW | Violator sequence number |
| viol_idx | output | IDXW | Violator slot |
| viol_count | output | CNTW | Violations seen |
| sq_free | input | CW | Store queue free entries |
| free_cnt | output | CW | Dispatchable memory operations |

## Verification
The bench places loads from several ages in one 256-byte block. A scan that failed to skip older loads, or that chose the youngest match instead of the oldest, would name the wrong slot. A probe sent while a violator is held would overwrite it in a design that ignores the hold. The bench also probes a block whose only match is a load that has not executed, so a design that checks unexecuted loads would raise a false fault. Squash bounds just below and just at the blocked sequence number show whether the comparison is strict. A dispatch while the queue is full, followed by a commit of everything, exposes a design that accepts loads past the reserved slot.

// File: rtl/load_order_queue.sv
module load_order_queue #(
  parameter int DEPTH   = 8,
  parameter int SEQW    = 16,
  parameter int ADDRW   = 32,
  parameter int BLK_LSB = 8,
  parameter int CNTW    = 16,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [SEQW-1:0]  disp_seq,
  output logic             disp_ready,
  output logic [IDXW-1:0]  disp_idx,
  input  logic             exec_valid,
  input  logic [IDXW-1:0]  exec_idx,
  input  logic [ADDRW-1:0] exec_addr,
  input  logic             st_valid,
  input  logic [SEQW-1:0]  st_seq,
  input  logic [ADDRW-1:0] st_addr,
  output logic             st_fault,
  input  logic             cmt_valid,
  input  logic [SEQW-1:0]  cmt_seq,
  input  logic             sqsh_valid,
  input  logic [SEQW-1:0]  sqsh_seq,
  input  logic             blk_set,
  input  logic [SEQW-1:0]  blk_seq,
  input  logic             blk_ack,
  output logic             blk_active,
  output logic             blk_handled,
  output logic [SEQW-1:0]  blk_seq_q,
  input  logic             viol_read,
  output logic             viol_valid,
  output logic [SEQW-1:0]  viol_seq,
  output logic [IDXW-1:0]  viol_idx,
  output logic [CNTW-1:0]  viol_count,
  input  logic [CW-1:0]    sq_free,
  output logic [CW-1:0]    free_cnt
);

  logic [DEPTH-1:0] held, ran;
  logic [SEQW-1:0]  lseq  [DEPTH];
  logic [ADDRW-1:0] laddr [DEPTH];

  logic [CW-1:0]   used, lq_free, tight;
  logic [IDXW-1:0] pick;
  logic            hit;
  logic [IDXW-1:0] hit_idx;
  logic [SEQW-1:0] hit_seq;
  logic [DEPTH-1:0] drop;

  always_comb begin
    used = '0;
    pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      used = used + CW'(held[i]);
      if (!held[i]) pick = IDXW'(i);
    end
  end

  assign disp_ready = used < CW'(DEPTH - 1);
  assign disp_idx   = pick;
  wire   take       = disp_valid && disp_ready;

  assign lq_free  = CW'(DEPTH) - used;
  assign tight    = (lq_free < sq_free) ? lq_free : sq_free;
  assign free_cnt = (tight == '0) ? '0 : tight - 1'b1;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    hit_seq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (held[i] && ran[i] && lseq[i] > st_seq &&
          laddr[i][ADDRW-1:BLK_LSB] == st_addr[ADDRW-1:BLK_LSB] &&
          (!hit || lseq[i] < hit_seq)) begin
        hit = 1'b1;
        hit_idx = IDXW'(i);
        hit_seq = lseq[i];
      end
    end
  end

  wire probe = st_valid && !viol_valid;

  always_comb
    for (int i = 0; i < DEPTH; i++)
      drop[i] = (cmt_valid && lseq[i] <= cmt_seq) || (sqsh_valid && lseq[i] > sqsh_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      ran  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lseq[i]  <= '0;
        laddr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (held[i] && drop[i]) begin
          held[i] <= 1'b0;
          ran[i]  <= 1'b0;
        end else if (held[i] && exec_valid && exec_idx == IDXW'(i)) begin
          ran[i]   <= 1'b1;
          laddr[i] <= exec_addr;
        end else if (!held[i] && take && pick == IDXW'(i)) begin
          held[i] <= 1'b1;
          ran[i]  <= 1'b0;
          lseq[i] <= disp_seq;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_seq   <= '0;
      viol_idx   <= '0;
      viol_count <= '0;
      st_fault   <= 1'b0;
    end else begin
      st_fault <= probe && hit;
      if (probe && hit) begin
        viol_valid <= 1'b1;
        viol_seq   <= hit_seq;
        viol_idx   <= hit_idx;
        viol_count <= viol_count + 1'b1;
      end else if (probe || viol_read) begin
        viol_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_active  <= 1'b0;
      blk_handled <= 1'b0;
      blk_seq_q   <= '0;
    end else if (sqsh_valid && sqsh_seq < blk_seq_q) begin
      blk_active  <= 1'b0;
      blk_handled <= 1'b0;
      blk_seq_q   <= '0;
    end else if (blk_set) begin
      blk_active  <= 1'b1;
      blk_handled <= 1'b0;
      blk_seq_q   <= blk_seq;
    end else if (blk_ack && blk_active) begin
      blk_handled <= 1'b1;
    end
  end

  assert_room_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CW'(DEPTH - 1));

  assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !cmt_valid && !sqsh_valid) |=> (used == $past(used)));

  assert_commit_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !disp_valid) |=> (used <= $past(used)));

  assert_fault_sets_violator_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault |-> viol_valid);

  assert_hold_violator_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_read) |=> (viol_valid && $stable(viol_seq) && $stable(viol_idx) && !st_fault));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && viol_read) |=> !viol_valid);

  assert_block_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sqsh_valid && sqsh_seq < blk_seq_q) |=> (!blk_active && !blk_handled));

  always_comb
    if (rst_n) assert_free_bound_R11: assert (free_cnt < lq_free || lq_free == '0);

endmodule

// File: tb/load_order_queue_test.sv
module load_order_queue_test;
  localparam int DEPTH = 8, SEQW = 16, ADDRW = 32, CNTW = 16;
  localparam int IDXW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, exec_valid = 0, st_valid = 0, cmt_valid = 0, sqsh_valid = 0;
  logic blk_set = 0, blk_ack = 0, viol_read = 0;
  logic [SEQW-1:0] disp_seq = 0, st_seq = 0, cmt_seq = 0, sqsh_seq = 0, blk_seq = 0;
  logic [IDXW-1:0] exec_idx = 0;
  logic [ADDRW-1:0] exec_addr = 0, st_addr = 0;
  logic [CW-1:0] sq_free = CW'(DEPTH);
  logic disp_ready, st_fault, blk_active, blk_handled, viol_valid;
  logic [IDXW-1:0] disp_idx, viol_idx;
  logic [SEQW-1:0] blk_seq_q, viol_seq;
  logic [CNTW-1:0] viol_count;
  logic [CW-1:0] free_cnt;

  int checks = 0, errors = 0;

  load_order_queue #(.DEPTH(DEPTH), .SEQW(SEQW), .ADDRW(ADDRW), .CNTW(CNTW)) uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_seq(disp_seq), .disp_ready(disp_ready), .disp_idx(disp_idx),
    .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_addr(exec_addr),
    .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr), .st_fault(st_fault),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .sqsh_valid(sqsh_valid), .sqsh_seq(sqsh_seq),
    .blk_set(blk_set), .blk_seq(blk_seq), .blk_ack(blk_ack), .blk_active(blk_active),
    .blk_handled(blk_handled), .blk_seq_q(blk_seq_q),
    .viol_read(viol_read), .viol_valid(viol_valid), .viol_seq(viol_seq), .viol_idx(viol_idx),
    .viol_count(viol_count), .sq_free(sq_free), .free_cnt(free_cnt));

  always #10 clk = ~clk;

  // {sq_free, expected free_cnt} with an empty queue
  localparam logic [7:0] FREE_TBL [4] = '{ {4'd8, 4'd7}, {4'd3, 4'd2}, {4'd0, 4'd0}, {4'd1, 4'd0} };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    disp_valid = 0; exec_valid = 0; st_valid = 0; cmt_valid = 0; sqsh_valid = 0;
    blk_set = 0; blk_ack = 0; viol_read = 0;
  endtask

  task automatic dispatch(input logic [SEQW-1:0] s, input int exp_idx, input string req);
    chk(req, 32'(disp_idx), 32'(exp_idx));
    disp_valid = 1; disp_seq = s; cyc();
  endtask

  task automatic exec(input int idx, input logic [ADDRW-1:0] a);
    exec_valid = 1; exec_idx = IDXW'(idx); exec_addr = a; cyc();
  endtask

  task automatic probe(input logic [SEQW-1:0] s, input logic [ADDRW-1:0] a);
    st_valid = 1; st_seq = s; st_addr = a; cyc();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    chk("R1 ready", 32'(disp_ready), 1);
    chk("R1 idx", 32'(disp_idx), 0);
    chk("R1 viol", 32'(viol_valid), 0);
    chk("R1 count", 32'(viol_count), 0);
    chk("R1 blocked", 32'({blk_active, blk_handled}), 0);
    chk("R1 blkseq", 32'(blk_seq_q), 0);

    for (int k = 0; k < 4; k++) begin
      sq_free = FREE_TBL[k][7:4];
      #1;
      chk("R11 table", 32'(free_cnt), 32'(FREE_TBL[k][3:0]));
    end
    sq_free = CW'(DEPTH);

    dispatch(10, 0, "R2 idx0");
    dispatch(20, 1, "R2 idx1");
    dispatch(30, 2, "R2 idx2");
    chk("R11 three held", 32'(free_cnt), 4);

    exec(0, 32'h1210);
    exec(1, 32'h1234);
    exec(2, 32'h1280);

    probe(15, 32'h12FF);
    chk("R7 fault", 32'(st_fault), 1);
    chk("R7 oldest seq", 32'(viol_seq), 20);
    chk("R7 oldest idx", 32'(viol_idx), 1);
    chk("R7 counter", 32'(viol_count), 1);

    probe(5, 32'h1200);
    chk("R8 no fault", 32'(st_fault), 0);
    chk("R8 counter", 32'(viol_count), 1);
    chk("R8 seq kept", 32'(viol_seq), 20);

    viol_read = 1; cyc();
    chk("R9 cleared", 32'(viol_valid), 0);

    probe(15, 32'h1300);
    chk("R6 other block", 32'(st_fault), 0);
    chk("R6 no viol", 32'(viol_valid), 0);

    probe(25, 32'h12C0);
    chk("R6 older skipped seq", 32'(viol_seq), 30);
    chk("R6 older skipped idx", 32'(viol_idx), 2);
    chk("R7 counter two", 32'(viol_count), 2);
    viol_read = 1; cyc();

    dispatch(40, 3, "R2 idx3");
    probe(35, 32'h0000);
    chk("R5 unexecuted", 32'(st_fault), 0);

    cmt_valid = 1; cmt_seq = 20; cyc();
    chk("R3 free", 32'(free_cnt), 5);
    chk("R3 idx back", 32'(disp_idx), 0);

    dispatch(50, 0, "R2 reuse");
    blk_set = 1; blk_seq = 45; cyc();
    chk("R10 set", 32'(blk_active), 1);
    chk("R10 seq", 32'(blk_seq_q), 45);

    sqsh_valid = 1; sqsh_seq = 44; cyc();
    chk("R10 released", 32'({blk_active, blk_handled}), 0);
    chk("R10 zero", 32'(blk_seq_q), 0);
    chk("R4 free", 32'(free_cnt), 5);
    chk("R4 idx", 32'(disp_idx), 0);

    probe(25, 32'h1200);
    chk("R4 kept load", 32'(viol_seq), 30);
    viol_read = 1; cyc();

    blk_set = 1; blk_seq = 35; cyc();
    blk_ack = 1; cyc();
    sqsh_valid = 1; sqsh_seq = 35; cyc();
    chk("R10 kept", 32'({blk_active, blk_handled}), 3);
    chk("R4 at bound", 32'(free_cnt), 6);

    dispatch(60, 0, "R2 fill");
    dispatch(70, 1, "R2 fill");
    dispatch(80, 3, "R2 fill");
    dispatch(90, 4, "R2 fill");
    dispatch(100, 5, "R2 fill");
    dispatch(110, 6, "R2 fill");
    chk("R2 full", 32'(disp_ready), 0);
    chk("R11 full", 32'(free_cnt), 0);

    disp_valid = 1; disp_seq = 200; cyc();
    cmt_valid = 1; cmt_seq = 150; cyc();
    chk("R2 refused", 32'(free_cnt), 7);
    chk("R3 all gone", 32'(disp_idx), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule